// File: doc/BRIEF.md
# UART Interrupt Status and Enable Controller

This block sits beside a serial port. It gathers the interrupt conditions of the receive FIFO, the transmit FIFO and the transmit shifter into one 32-bit status word, and combines that word with a 32-bit enable word into a single interrupt request.

The status word holds two kinds of bit:

- **Sticky event bits.** Receive overrun and receive parity error are captured from one-cycle event pulses. They hold until software writes a 1 to their position.
- **Live level bits.** All other status bits are decoded each cycle from the FIFO occupancy counts and the receiver and shifter state inputs. They follow those inputs and ignore writes.

Software reaches both words through a simple register port:

- `addr_i` = 0 selects the status word.
- `addr_i` = 1 selects the enable word.
- Reads return data combinationally.
- Writes take effect at the next clock edge.

The interrupt output is registered. It rises one cycle after any status bit and its enable bit are both 1.

Top module: `uart_irq_ctrl`

## Requirements

- R1: After reset, the enable word reads 0, both sticky bits (2 and 4) read 0, and `irq_o` is 0.
- R2: Status bit 2 (receive overrun) is set by a one-cycle pulse on `rx_overrun_i`. It stays 1 through status writes that carry 0 in bit 2. It clears at the edge of a status write (`addr_i`=0) that carries 1 in bit 2.
- R3: When an overrun pulse and a status write with bit 2 set fall in the same cycle, the set wins and bit 2 reads 1 afterwards.
- R4: Status bit 0 reads 1 exactly when `rx_level_i` equals DEPTH. Status bit 1 reads 1 exactly when `rx_level_i` is at least DEPTH/2. Status writes do not change either bit.
- R5: Status bit 3 reads 1 exactly when `rx_level_i` is 0. Status bit 6 reads 1 exactly when `rx_level_i` is nonzero. Status bit 5 follows `rx_busy_i`.
- R6: Status bit 4 (receive parity error) is set by a pulse on `rx_parity_err_i`. It holds until a status write carries 1 in bit 4.
- R7: The transmit status bits are decoded as follows:
  - Bit 8 reads 1 when `tx_level_i` is 0.
  - Bit 9 reads 1 when `tx_level_i` is at most DEPTH/2.
  - Bit 10 follows `tx_shift_empty_i`.
  - Bit 11 reads 1 when `tx_level_i` is 0 and `tx_shift_empty_i` is 1.
- R8: The enable word is written and read at `addr_i`=1. Bit 7 and bits 31:12 of both words read 0, so writing all ones to the enable word reads back 0x00000F7F.
- R9: `irq_o` becomes 1 one cycle after some status bit and the matching enable bit are both 1. It returns to 0 one cycle after no such pair remains.
- R10: A source whose enable bit is 0 never raises `irq_o`. This holds in particular for parity error (enable bit 4) and receiver-not-idle (enable bit 5).

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when 1 (with req_i) |
| addr_i | input | 1 | 0 selects status, 1 selects enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the selected word |
| rx_level_i | input | CNT_W | Receive FIFO occupancy, 0 to DEPTH |
| tx_level_i | input | CNT_W | Transmit FIFO occupancy, 0 to DEPTH |
| rx_overrun_i | input | 1 | Receive overrun event pulse |
| rx_parity_err_i | input | 1 | Receive parity error event pulse |
| rx_busy_i | input | 1 | Receiver not idle |
| tx_shift_empty_i | input | 1 | Transmit shift register empty |
| irq_o | output | 1 | Interrupt request, registered |

## Verification

The bench builds the block with the default DEPTH of 16. The occupancy inputs are then 5 bits wide, and the half threshold is 8. This brings both sides of each threshold within reach:

- receive levels 7, 8 and 16;
- transmit levels 0, 8 and 9.

Interrupt tests pair exactly one enabled source with the others masked. They show both the one-cycle registered delay and the masking of the parity and receiver-busy sources.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned REG_W = 32;

  localparam int B_RX_FULL   = 0;
  localparam int B_RX_HALF   = 1;
  localparam int B_RX_OVR    = 2;
  localparam int B_RX_EMPTY  = 3;
  localparam int B_RX_PAR    = 4;
  localparam int B_RX_BUSY   = 5;
  localparam int B_RX_NEMPTY = 6;
  localparam int B_TX_EMPTY  = 8;
  localparam int B_TX_HALF   = 9;
  localparam int B_TX_SHEMP  = 10;
  localparam int B_TX_NODATA = 11;

  localparam logic [REG_W-1:0] EN_MASK = 32'h0000_0F7F;

  typedef enum logic {
    ADDR_STATUS = 1'b0,
    ADDR_ENABLE = 1'b1
  } reg_addr_e;
endpackage

// File: rtl/uart_irq_levels.sv
module uart_irq_levels
  import uart_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] rx_level_i,
  input  logic [CNT_W-1:0] tx_level_i,
  input  logic             rx_busy_i,
  input  logic             tx_shift_empty_i,
  output logic [REG_W-1:0] lvl_o
);
  localparam logic [CNT_W-1:0] FULL_L = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_L = CNT_W'(DEPTH / 2);

  logic rx_empty, tx_empty;

  assign rx_empty = (rx_level_i == '0);
  assign tx_empty = (tx_level_i == '0);

  always_comb begin
    lvl_o              = '0;
    lvl_o[B_RX_FULL]   = (rx_level_i == FULL_L);
    lvl_o[B_RX_HALF]   = (rx_level_i >= HALF_L);
    lvl_o[B_RX_EMPTY]  = rx_empty;
    lvl_o[B_RX_BUSY]   = rx_busy_i;
    lvl_o[B_RX_NEMPTY] = !rx_empty;
    lvl_o[B_TX_EMPTY]  = tx_empty;
    lvl_o[B_TX_HALF]   = (tx_level_i <= HALF_L);
    lvl_o[B_TX_SHEMP]  = tx_shift_empty_i;
    lvl_o[B_TX_NODATA] = tx_empty && tx_shift_empty_i;
  end

  always_comb begin
    AST_FULL_IMPLIES_HALF: assert (!(lvl_o[B_RX_FULL] && !lvl_o[B_RX_HALF])); // R4
    AST_EMPTY_XOR_NEMPTY: assert (lvl_o[B_RX_EMPTY] != lvl_o[B_RX_NEMPTY]); // R5
  end
endmodule

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;  // set beats clear
      else if (clr_i[i]) q_o[i] <= 1'b0;
    end

    AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q_o[i] && !clr_i[i]) |=> q_o[i]); // R2
    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> q_o[i]); // R3
  end
endmodule

// File: rtl/uart_irq_enable.sv
module uart_irq_enable
  import uart_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_o <= '0;
    else if (we_i) en_o <= wdata_i & EN_MASK;
  end

  AST_EN_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((en_o & ~EN_MASK) == '0)); // R8
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic [CNT_W-1:0] rx_level_i,
  input  logic [CNT_W-1:0] tx_level_i,
  input  logic             rx_overrun_i,
  input  logic             rx_parity_err_i,
  input  logic             rx_busy_i,
  input  logic             tx_shift_empty_i,
  output logic             irq_o
);
  localparam int unsigned NSTICKY = 2;

  logic             st_we, en_we;
  logic [REG_W-1:0] lvl, en, status;
  logic [NSTICKY-1:0] stk_set, stk_clr, stk_q;
  logic             irq_q;

  assign st_we = req_i && we_i && (reg_addr_e'(addr_i) == ADDR_STATUS);
  assign en_we = req_i && we_i && (reg_addr_e'(addr_i) == ADDR_ENABLE);

  uart_irq_levels #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_levels (
    .rx_level_i       (rx_level_i),
    .tx_level_i       (tx_level_i),
    .rx_busy_i        (rx_busy_i),
    .tx_shift_empty_i (tx_shift_empty_i),
    .lvl_o            (lvl)
  );

  assign stk_set = {rx_parity_err_i, rx_overrun_i};
  assign stk_clr = {wdata_i[B_RX_PAR], wdata_i[B_RX_OVR]} & {NSTICKY{st_we}};

  uart_irq_sticky #(.N(NSTICKY)) u_sticky (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (stk_set),
    .clr_i  (stk_clr),
    .q_o    (stk_q)
  );

  uart_irq_enable u_enable (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (en_we),
    .wdata_i (wdata_i),
    .en_o    (en)
  );

  always_comb begin
    status           = lvl;
    status[B_RX_OVR] = stk_q[0];
    status[B_RX_PAR] = stk_q[1];
  end

  assign rdata_o = (reg_addr_e'(addr_i) == ADDR_ENABLE) ? en : status;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(status & en);
  end

  assign irq_o = irq_q;

  AST_RXFULL_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rx_level_i == CNT_W'(DEPTH)) && en[B_RX_FULL]) |=> irq_o); // R9
  AST_MASKED_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |=> !irq_o); // R10
  AST_OVR_SETS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_overrun_i |=> status[B_RX_OVR]); // R2
endmodule

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req = 1'b0, we = 1'b0, addr = 1'b0;
  logic [31:0]      wdata = '0;
  logic [31:0]      rdata;
  logic [CNT_W-1:0] rx_level = '0, tx_level = '0;
  logic             ovr = 1'b0, par = 1'b0, busy = 1'b0, shemp = 1'b1;
  logic             irq;

  int checks = 0;
  int errors = 0;
  logic m_ovr = 1'b0, m_par = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ctrl #(.DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rx_level_i(rx_level), .tx_level_i(tx_level),
    .rx_overrun_i(ovr), .rx_parity_err_i(par), .rx_busy_i(busy),
    .tx_shift_empty_i(shemp), .irq_o(irq)
  );

  function automatic logic [31:0] model_status();
    logic [31:0] s = '0;
    s[0]  = (rx_level == DEPTH);
    s[1]  = (rx_level >= DEPTH/2);
    s[2]  = m_ovr;
    s[3]  = (rx_level == 0);
    s[4]  = m_par;
    s[5]  = busy;
    s[6]  = (rx_level != 0);
    s[8]  = (tx_level == 0);
    s[9]  = (tx_level <= DEPTH/2);
    s[10] = shemp;
    s[11] = (tx_level == 0) && shemp;
    return s;
  endfunction

  task automatic chk(input string req_s, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req_s, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse_ovr();
    @(negedge clk); ovr = 1'b1;
    @(negedge clk); ovr = 1'b0;
  endtask

  task automatic pulse_par();
    @(negedge clk); par = 1'b1;
    @(negedge clk); par = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(1'b1, d); chk("R1 enable", d, 32'h0);
    rd(1'b0, d); chk("R1 status", d, 32'h0000_0F08);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_overrun();
    logic [31:0] d;
    pulse_ovr(); m_ovr = 1'b1;
    rd(1'b0, d); chk("R2 set", d, model_status());
    wr(1'b0, 32'hFFFF_FFEB);
    rd(1'b0, d); chk("R2 hold on write0", d, model_status());
    wr(1'b0, 32'h0000_0004); m_ovr = 1'b0;
    rd(1'b0, d); chk("R2 w1c", d, model_status());
  endtask

  task automatic t_set_priority();
    logic [31:0] d;
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 1'b0; wdata = 32'h4; ovr = 1'b1;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0; ovr = 1'b0;
    m_ovr = 1'b1;
    rd(1'b0, d); chk("R3 set wins", {29'b0, d[2], 2'b0}, 32'h4);
    wr(1'b0, 32'h4); m_ovr = 1'b0;
    rd(1'b0, d); chk("R3 cleared later", d, model_status());
  endtask

  task automatic t_rx_levels();
    logic [31:0] d;
    @(negedge clk); rx_level = CNT_W'(DEPTH/2 - 1);
    rd(1'b0, d); chk("R4 below half", d, model_status());
    @(negedge clk); rx_level = CNT_W'(DEPTH/2);
    rd(1'b0, d); chk("R4 at half", d, model_status());
    @(negedge clk); rx_level = CNT_W'(DEPTH);
    rd(1'b0, d); chk("R4 full", d, model_status());
    wr(1'b0, 32'h0000_0003);
    rd(1'b0, d); chk("R4 write ignored", d, model_status());
    @(negedge clk); rx_level = '0;
    rd(1'b0, d); chk("R5 rx empty", d, model_status());
  endtask

  task automatic t_rx_busy();
    logic [31:0] d;
    @(negedge clk); busy = 1'b1; rx_level = CNT_W'(3);
    rd(1'b0, d); chk("R5 busy nonempty", d, model_status());
    @(negedge clk); busy = 1'b0; rx_level = '0;
    rd(1'b0, d); chk("R5 idle", d, model_status());
  endtask

  task automatic t_parity();
    logic [31:0] d;
    pulse_par(); m_par = 1'b1;
    repeat (2) @(negedge clk);
    rd(1'b0, d); chk("R6 sticky", d, model_status());
    wr(1'b0, 32'h0000_0010); m_par = 1'b0;
    rd(1'b0, d); chk("R6 w1c", d, model_status());
  endtask

  task automatic t_tx();
    logic [31:0] d;
    @(negedge clk); tx_level = CNT_W'(DEPTH/2);
    rd(1'b0, d); chk("R7 tx at half", d, model_status());
    @(negedge clk); tx_level = CNT_W'(DEPTH/2 + 1);
    rd(1'b0, d); chk("R7 tx above half", d, model_status());
    @(negedge clk); tx_level = '0; shemp = 1'b0;
    rd(1'b0, d); chk("R7 shifter busy", d, model_status());
    @(negedge clk); shemp = 1'b1;
    rd(1'b0, d); chk("R7 no data", d, model_status());
  endtask

  task automatic t_enable_rw();
    logic [31:0] d;
    wr(1'b1, 32'hFFFF_FFFF);
    rd(1'b1, d); chk("R8 enable rsvd", d, 32'h0000_0F7F);
    wr(1'b1, 32'h0000_0000);
    rd(1'b1, d); chk("R8 enable clear", d, 32'h0);
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, d); chk("R8 status rsvd", d & 32'hFFFF_F080, 32'h0);
  endtask

  task automatic t_irq();
    @(negedge clk); rx_level = CNT_W'(DEPTH);
    @(negedge clk);
    chk("R9 no irq while masked", {31'b0, irq}, 32'h0);
    wr(1'b1, 32'h0000_0001);
    chk("R9 irq lags enable", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R9 irq raised", {31'b0, irq}, 32'h1);
    rx_level = '0;
    #1;
    chk("R9 irq held one cycle", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R9 irq dropped", {31'b0, irq}, 32'h0);
    wr(1'b1, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    pulse_par(); m_par = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 parity masked", {31'b0, irq}, 32'h0);
    wr(1'b1, 32'h0000_0010);
    @(negedge clk);
    chk("R10 parity enabled", {31'b0, irq}, 32'h1);
    wr(1'b0, 32'h0000_0010); m_par = 1'b0;
    @(negedge clk);
    chk("R10 parity cleared", {31'b0, irq}, 32'h0);
    @(negedge clk); busy = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 busy masked", {31'b0, irq}, 32'h0);
    wr(1'b1, 32'h0000_0020);
    @(negedge clk);
    chk("R10 busy enabled", {31'b0, irq}, 32'h1);
    wr(1'b1, 32'h0); busy = 1'b0;
    rd(1'b0, d); chk("R10 status", d, model_status());
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_overrun();
    t_set_priority();
    t_rx_levels();
    t_rx_busy();
    t_parity();
    t_tx();
    t_enable_rw();
    t_irq();
    t_mask();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule